// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers sixteen interrupt sources for a single processor and presents them through a small 32-bit register port. Even-numbered sources arrive on asynchronous external pins. They are active low, and each one can be set to trigger on a falling edge or on a low level. Odd-numbered sources are synchronous, active-high level inputs from on-chip logic.

Each source has a latched pending bit and an enable bit. The block drives one registered interrupt request to the processor. Software finds out which source to service by reading a vector register, which holds the code of the most urgent pending, enabled source.

All three source registers number their bits from the most significant end: source n sits at bit 31-n. Software acknowledges an edge-latched request by writing a 1 to that source's pending bit.

Top module: `irqc_top`

## Requirements
- R1: Register offsets (addr_i[3:2]) are pending 0x0, enable 0x4, sense 0x8 and vector 0xC. In the pending, enable and sense registers, source n occupies bit 31-n, and bits 15:0 read as 0.
- R2: After reset the pending, enable and sense registers read 0, irq_o is 0, and the vector reads 0x3C00_0000.
- R3: A write to the enable register replaces all sixteen enable bits, and they read back unchanged. A 1 enables the source.
- R4: Only even-numbered sources have a sense bit. Writing all ones to the sense register reads back 0xAAAA_0000, because writes to the odd sources' bits are ignored.
- R5: An external pin passes through two synchronizer flops. A pin change driven between rising edges appears in the pending register after the third rising edge, and not after the second.
- R6: With sense bit 1 (edge mode), a high-to-low transition of the external pin sets the pending bit. The bit stays set after the pin returns high, until it is acknowledged.
- R7: With sense bit 0 (level mode), an external source's pending bit follows the inverted pin. An odd source's pending bit follows its input directly. A level source cannot be cleared while its input is asserted.
- R8: Writing the pending register clears each edge-latched bit written as 1. Bits written as 0 are unaffected.
- R9: Among pending, enabled sources, the lowest-numbered one wins. The vector register carries its number in bits 31:26, and all other vector bits read 0.
- R10: The vector reports code 15 when no enabled source is pending.
- R11: irq_o is high exactly one clock after any pending bit with its enable bit set becomes visible.
- R12: Writes to the vector register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the register port |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ext_i | input | 8 | External pins, active low; bit k is source 2k |
| int_i | input | 8 | Internal level inputs, active high; bit k is source 2k+1 |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Random rounds use a random enable word, a random edge/level split on the external sources, and random pin and internal-input patterns.

Each round reads the block in three phases:
- While the inputs are asserted, edge and level sources look the same. This phase checks the priority choice and the vector code.
- Once the pins return high, only edge-latched bits should remain. This separates the edge sources from the level sources.
- After a random acknowledge word, the edge bits written as 1 must drop, while asserted internal levels must survive. This separates the acknowledge from level tracking.

Directed cases pin down the synchronizer and request latencies cycle by cycle, the ignored odd sense bits and vector writes, and the idle code.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_EN   = 2'd1,
    REG_SENS = 2'd2,
    REG_VEC  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W         = 8,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= {W{RESET_VAL}};
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= {W{RESET_VAL}};
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqc_src.sv
module irqc_src #(
  parameter int N_SRC = 16,
  localparam int HALF = N_SRC / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [HALF-1:0]  ext_s_i,   // synchronized, active low
  input  logic [HALF-1:0]  int_i,     // active high
  input  logic [N_SRC-1:0] sense_i,   // 1 = falling edge
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    if (n % 2 == 0) begin : g_ext
      logic prev_q;
      logic fall;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b1;
        else         prev_q <= ext_s_i[n/2];
      end

      assign fall = prev_q & ~ext_s_i[n/2];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         pend_q[n] <= 1'b0;
        else if (sense_i[n]) pend_q[n] <= fall | (pend_q[n] & ~clr_i[n]);
        else                 pend_q[n] <= ~ext_s_i[n/2];
      end

      // R7
      ext_lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sense_i[n] && !ext_s_i[n/2]) |=> pend_q[n]);
      // R6
      edge_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sense_i[n] && pend_q[n] && !clr_i[n]) |=> pend_q[n]);
    end else begin : g_int
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q[n] <= 1'b0;
        else         pend_q[n] <= int_i[n/2];
      end

      // R7
      int_lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_i[n/2] |=> pend_q[n]);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N_SRC  = 16,
  parameter int CODE_W = 6,
  parameter int IDLE   = 15
) (
  input  logic [N_SRC-1:0]  act_i,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    code_o = CODE_W'(IDLE);
    for (int n = N_SRC - 1; n >= 0; n--) begin
      if (act_i[n]) code_o = CODE_W'(n);
    end
  end

  // R9
  vec_hit_chk: assert final (!(|act_i) || act_i[code_o]);
  // R9
  vec_first_chk: assert final (!(|act_i) ||
    ((act_i & ((N_SRC'(1) << code_o) - N_SRC'(1))) == '0));
  // R10
  vec_idle_chk: assert final ((|act_i) || code_o == CODE_W'(IDLE));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int ADDR_W = 4,
  parameter int IDLE   = 15,
  localparam int HALF    = N_SRC / 2,
  localparam int VEC_LSB = DATA_W - CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [HALF-1:0]   ext_i,
  input  logic [HALF-1:0]   int_i,
  output logic              irq_o
);
  logic [HALF-1:0]   ext_s;
  logic [N_SRC-1:0]  wsrc, en_q, sense_q, clr, pend, act;
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] pend_bus, en_bus, sense_bus;
  logic              irq_q;
  reg_sel_e          rsel;

  assign rsel = reg_sel_e'(addr_i[3:2]);

  // source n <-> bus bit DATA_W-1-n
  for (genvar n = 0; n < N_SRC; n++) begin : g_map
    assign wsrc[n]                = wdata_i[DATA_W-1-n];
    assign pend_bus[DATA_W-1-n]   = pend[n];
    assign en_bus[DATA_W-1-n]     = en_q[n];
    assign sense_bus[DATA_W-1-n]  = sense_q[n];
  end
  if (DATA_W > N_SRC) begin : g_pad
    assign pend_bus[DATA_W-N_SRC-1:0]  = '0;
    assign en_bus[DATA_W-N_SRC-1:0]    = '0;
    assign sense_bus[DATA_W-N_SRC-1:0] = '0;
  end

  irqc_sync #(.W(HALF), .STAGES(2), .RESET_VAL(1'b1)) i_sync (
    .clk_i, .rst_ni, .d_i(ext_i), .q_o(ext_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       en_q <= '0;
    else if (wr_i && rsel == REG_EN)   en_q <= wsrc;
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_sense
    if (n % 2 == 0) begin : g_prog
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        sense_q[n] <= 1'b0;
        else if (wr_i && rsel == REG_SENS)  sense_q[n] <= wsrc[n];
      end
    end else begin : g_fixed
      assign sense_q[n] = 1'b0;
    end
  end

  assign clr = (wr_i && rsel == REG_PEND) ? wsrc : '0;

  irqc_src #(.N_SRC(N_SRC)) i_src (
    .clk_i, .rst_ni, .ext_s_i(ext_s), .int_i, .sense_i(sense_q),
    .clr_i(clr), .pend_o(pend)
  );

  assign act = pend & en_q;

  irqc_prio #(.N_SRC(N_SRC), .CODE_W(CODE_W), .IDLE(IDLE)) i_prio (
    .act_i(act), .code_o(code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |act;
  end
  assign irq_o = irq_q;

  always_comb begin
    unique case (rsel)
      REG_PEND: rdata_o = pend_bus;
      REG_EN:   rdata_o = en_bus;
      REG_SENS: rdata_o = sense_bus;
      REG_VEC:  rdata_o = {code, {VEC_LSB{1'b0}}};
      default:  rdata_o = '0;
    endcase
  end

  // R11
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|act));
  // R11
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> !$past(|act));
  // R12
  vec_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rsel == REG_VEC) |=> ($stable(en_q) && $stable(sense_q)));
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
  localparam int N = 16;
  localparam int H = N / 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [H-1:0] ext_i = '1;
  logic [H-1:0] int_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  irqc_top i_irqc_top (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o, .ext_i, .int_i, .irq_o
  );

  function automatic logic [31:0] to_bus(logic [N-1:0] s);
    logic [31:0] w = '0;
    for (int n = 0; n < N; n++) w[31-n] = s[n];
    return w;
  endfunction

  function automatic logic [31:0] exp_vec(logic [N-1:0] p, logic [N-1:0] m);
    logic [5:0] c = 6'd15;
    for (int n = N - 1; n >= 0; n--) if (p[n] && m[n]) c = 6'(n);
    return {c, 26'd0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] mask, sense, pexp, ack;
    logic [H-1:0] e, iv;
    void'($urandom(32'd4242));
    #12 rst_ni = 1'b1;

    // R2 reset state
    rd(4'h0, d); chk("R2 pend", d, 32'h0);
    rd(4'h4, d); chk("R2 en", d, 32'h0);
    rd(4'h8, d); chk("R2 sense", d, 32'h0);
    rd(4'hC, d); chk("R2 vec", d, 32'h3C00_0000);
    chk("R2 irq", {31'd0, irq_o}, 32'h0);

    // R3 enable write/readback
    wr(4'h4, 32'hDEAD_BEEF);
    rd(4'h4, d); chk("R3 en", d, 32'hDEAD_0000);
    // R4 odd sense bits ignored
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R4 sense", d, 32'hAAAA_0000);
    // R12 vector write ignored
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, d); chk("R12 vec", d, 32'h3C00_0000);
    rd(4'h4, d); chk("R12 en", d, 32'hDEAD_0000);
    rd(4'h8, d); chk("R12 sense", d, 32'hAAAA_0000);

    // R5 synchronizer latency, source 0 level mode
    wr(4'h8, 32'h0);
    wr(4'h4, 32'h8000_0000);
    addr_i = 4'h0;
    @(negedge clk_i); ext_i[0] = 1'b0;
    @(posedge clk_i); @(posedge clk_i); #1;
    chk("R5 after 2 edges", rdata_o, 32'h0);
    @(posedge clk_i); #1;
    chk("R5 after 3 edges", rdata_o, 32'h8000_0000);
    chk("R11 irq not yet", {31'd0, irq_o}, 32'h0);
    @(posedge clk_i); #1;
    chk("R11 irq one later", {31'd0, irq_o}, 32'h1);
    ext_i[0] = 1'b1;
    wait_cyc(5);

    // R11 internal source 1 latency
    wr(4'h4, 32'h4000_0000);
    @(negedge clk_i); int_i[0] = 1'b1; addr_i = 4'h0;
    @(posedge clk_i); #1;
    chk("R7 int follows", rdata_o, 32'h4000_0000);
    chk("R11 irq lag", {31'd0, irq_o}, 32'h0);
    @(posedge clk_i); #1;
    chk("R11 irq up", {31'd0, irq_o}, 32'h1);
    // R7 level cannot be cleared while asserted
    wr(4'h0, 32'h4000_0000);
    rd(4'h0, d); chk("R7 no clear", d, 32'h4000_0000);
    rd(4'hC, d); chk("R9 vec src1", d, 32'h0400_0000);
    int_i[0] = 1'b0;
    wait_cyc(3);
    rd(4'hC, d); chk("R10 idle", d, 32'h3C00_0000);

    // random rounds
    for (int r = 0; r < 60; r++) begin
      mask  = N'($urandom);
      sense = N'($urandom) & 16'h5555;
      ext_i = '1; int_i = '0;
      wr(4'h4, to_bus(mask));
      wr(4'h8, to_bus(sense));
      wait_cyc(4);
      wr(4'h0, 32'hFFFF_0000);
      wait_cyc(2);
      e  = H'($urandom);
      iv = H'($urandom);
      ext_i = e; int_i = iv;
      wait_cyc(5);
      pexp = '0;
      for (int k = 0; k < H; k++) begin
        pexp[2*k]   = ~e[k];
        pexp[2*k+1] = iv[k];
      end
      rd(4'h0, d); chk("R6 R7 pend asserted", d, to_bus(pexp));
      rd(4'hC, d); chk("R9 vec", d, exp_vec(pexp, mask));
      chk("R11 irq", {31'd0, irq_o}, {31'd0, |(pexp & mask)});
      ext_i = '1;
      wait_cyc(5);
      for (int k = 0; k < H; k++) pexp[2*k] = ~e[k] & sense[2*k];
      rd(4'h0, d); chk("R6 edge held", d, to_bus(pexp));
      rd(4'hC, d); chk("R10 R9 vec", d, exp_vec(pexp, mask));
      ack = N'($urandom);
      wr(4'h0, to_bus(ack));
      wait_cyc(1);
      for (int k = 0; k < H; k++) pexp[2*k] = pexp[2*k] & ~ack[2*k];
      rd(4'h0, d); chk("R8 ack", d, to_bus(pexp));
      rd(4'hC, d); chk("R9 vec after ack", d, exp_vec(pexp, mask));
      chk("R11 irq after ack", {31'd0, irq_o}, {31'd0, |(pexp & mask)});
    end

    // R1 all sources enabled, each alone: vector and bit position
    ext_i = '1; int_i = '0;
    wr(4'h8, 32'h0);
    wr(4'h4, 32'hFFFF_0000);
    for (int k = 0; k < H; k++) begin
      int_i = '0; int_i[k] = 1'b1;
      wait_cyc(2);
      rd(4'h0, d); chk("R1 bit pos", d, 32'h8000_0000 >> (2*k+1));
      rd(4'hC, d); chk("R1 vec code", d, {6'(2*k+1), 26'd0});
    end
    int_i = '0;
    wait_cyc(3);
    finish_run();
  end
endmodule